// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block lets a host configure one of up to 64 devices that share a single three-wire control bus: an active-low chip select, a serial clock and serial data. The host writes a transaction of two to four bytes. Each byte is sent least significant bit first and sampled on the rising serial clock edge while chip select is low. The first byte carries a six-bit device address and a channel selector. A device whose address straps match that address accepts the remaining bytes: a control byte, then optionally an input time-slot byte and an output time-slot byte, all for the X or Y side.

All three serial wires are brought into the processing clock through multi-stage synchronizers. They are oversampled there, so the whole port runs on one clock and the serial clock may be asynchronous to it. Received bytes are held in staging registers. They are copied into the channel registers only when chip select returns high. While a matched write is in progress, a high-impedance request tells the channel data outputs to float. A hardware-mode strap shuts the port off. The processing engine signals the end of a channel's coefficient reset, and that signal clears the channel's algorithm-reset bit.

Top module: `addr_cfg_port`

## Requirements
- R1: After reset both control registers read 8'h20 (only the idle/power-down bit, bit 5, set), all four time-slot registers read 0 and `out_hiz` is low.
- R2: With chip select low, bits are sampled on rising `sclk` edges, each byte LSB first. In the first byte, bit 6 selects the channel (1 = X, 0 = Y) and bits 5..0 are the device address with bit 5 as the MSB. The second byte of a matching transaction becomes that channel's control register.
- R3: If first-byte bits 5..0 differ from `dev_addr`, no register changes and `out_hiz` stays low for the whole transaction.
- R4: A first byte with bit 7 set is treated as not addressed to this device: no register changes and `out_hiz` stays low.
- R5: A matching two-byte transaction updates only the control register and leaves both time-slot registers of that channel unchanged.
- R6: In a matching transaction, bits 5..0 of the third byte become the input time slot and bits 5..0 of the fourth byte become the output time slot. A three-byte transaction updates the input time slot only. The other channel is never touched.
- R7: Bytes after the fourth are ignored, and a trailing partial byte (fewer than 8 bits) is discarded without affecting any register.
- R8: `out_hiz` rises within a few clocks after a matching address byte completes. It stays high while chip select is low and falls on the same clock edge on which the received values are committed, a few clocks after chip select rises.
- R9: A pulse on `coef_rst_done[1]` clears bit 4 of the X control register and a pulse on `coef_rst_done[0]` clears bit 4 of the Y control register. All other bits are kept.
- R10: While `hw_mode` is high the port ignores all serial traffic and `out_hiz` stays low.
- R11: Register outputs keep their old values throughout a transaction and change only after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | Hardware-mode strap; high disables the port |
| dev_addr | input | 6 | Device address straps |
| csn | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, LSB first |
| coef_rst_done | input | 2 | Coefficient reset finished, [1] = X, [0] = Y |
| out_hiz | output | 1 | Request to float both channel data outputs |
| ctrl_x | output | 8 | X control register |
| its_x | output | 6 | X input time slot |
| ots_x | output | 6 | X output time slot |
| ctrl_y | output | 8 | Y control register |
| its_y | output | 6 | Y input time slot |
| ots_y | output | 6 | Y output time slot |

## Verification
A wrong bit or byte counter shows up as a control or slot value that is shifted or taken from the wrong byte. That error is visible at the register outputs within a few clocks of chip select rising. A stuck or wrong address-match state shows up twice: in the middle of the transaction as a wrong `out_hiz` level, and after it as a commit to a foreign address or a missing commit. A sweep over all 64 addresses, together with transactions of two, three, four and five bytes and a truncated one, makes each counter state and both channel selections affect an output at least once.

// File: rtl/addr_cfg_port.sv
module addr_cfg_port #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_mode,
  input  logic [5:0] dev_addr,
  input  logic       csn,
  input  logic       sclk,
  input  logic       sdi,
  input  logic [1:0] coef_rst_done,
  output logic       out_hiz,
  output logic [7:0] ctrl_x,
  output logic [5:0] its_x,
  output logic [5:0] ots_x,
  output logic [7:0] ctrl_y,
  output logic [5:0] its_y,
  output logic [5:0] ots_y
);
  localparam int         BYTE_W   = 8;
  localparam int         SLOT_W   = 6;
  localparam int         CNT_W    = $clog2(BYTE_W);
  localparam logic [7:0] CTRL_RST = 8'h20;

  logic [SYNC_DEPTH:0]   sclk_s, csn_s;
  logic [SYNC_DEPTH-1:0] sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0;
      csn_s  <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_DEPTH-1:0], sclk};
      csn_s  <= {csn_s[SYNC_DEPTH-1:0], csn};
      sdi_s  <= {sdi_s[SYNC_DEPTH-2:0], sdi};
    end

  wire sclk_rise = sclk_s[SYNC_DEPTH-1] & ~sclk_s[SYNC_DEPTH];
  wire cs_low    = ~csn_s[SYNC_DEPTH-1] & ~hw_mode;
  wire cs_end    = csn_s[SYNC_DEPTH-1] & ~csn_s[SYNC_DEPTH] & ~hw_mode;

  logic [CNT_W-1:0]  bit_cnt;
  logic [2:0]        byte_cnt;
  logic [BYTE_W-1:0] shreg, st_ctrl;
  logic [SLOT_W-1:0] st_its, st_ots;
  logic              addr_ok, sel_x;

  wire [BYTE_W-1:0] byte_in   = {sdi_s[SYNC_DEPTH-1], shreg[BYTE_W-1:1]};
  wire              last_bit  = bit_cnt == CNT_W'(BYTE_W - 1);
  wire              byte_done = cs_low & sclk_rise & last_bit;
  wire              commit    = cs_end & addr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      st_ctrl  <= '0;
      st_its   <= '0;
      st_ots   <= '0;
      addr_ok  <= 1'b0;
      sel_x    <= 1'b0;
    end else if (!cs_low) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      addr_ok  <= 1'b0;
    end else if (sclk_rise) begin
      shreg   <= byte_in;
      bit_cnt <= bit_cnt + 1'b1;
      if (last_bit) begin
        case (byte_cnt)
          3'd0: begin
            addr_ok <= ~byte_in[7] & (byte_in[5:0] == dev_addr);
            sel_x   <= byte_in[6];
          end
          3'd1: st_ctrl <= byte_in;
          3'd2: st_its  <= byte_in[SLOT_W-1:0];
          3'd3: st_ots  <= byte_in[SLOT_W-1:0];
          default: ;
        endcase
        if (byte_cnt != 3'd4) byte_cnt <= byte_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_x <= CTRL_RST;
      ctrl_y <= CTRL_RST;
      its_x  <= '0;
      ots_x  <= '0;
      its_y  <= '0;
      ots_y  <= '0;
    end else begin
      if (coef_rst_done[1]) ctrl_x[4] <= 1'b0;
      if (coef_rst_done[0]) ctrl_y[4] <= 1'b0;
      if (commit) begin
        if (byte_cnt >= 3'd2) begin
          if (sel_x) ctrl_x <= st_ctrl;
          else       ctrl_y <= st_ctrl;
        end
        if (byte_cnt >= 3'd3) begin
          if (sel_x) its_x <= st_its;
          else       its_y <= st_its;
        end
        if (byte_cnt >= 3'd4) begin
          if (sel_x) ots_x <= st_ots;
          else       ots_y <= st_ots;
        end
      end
    end

  assign out_hiz = addr_ok;

  // R10
  hw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> !out_hiz);

  // R8
  hiz_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_hiz) |-> $past(byte_done));

  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({its_x, ots_x, its_y, ots_y}));

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && coef_rst_done == 2'b00) |=> $stable({ctrl_x, ctrl_y}));

  // R9
  alrst_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_rst_done[1] && !(commit && sel_x)) |=> !ctrl_x[4]);

  // R9
  alrst_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_rst_done[0] && !(commit && !sel_x)) |=> !ctrl_y[4]);
endmodule

// File: tb/test_addr_cfg_port.sv
module test_addr_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] DEV = 6'h2D;

  logic clk = 1'b0, rst_n = 1'b0, hw_mode = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [1:0] coef_rst_done = 2'b00;
  logic out_hiz;
  logic [7:0] ctrl_x, ctrl_y;
  logic [5:0] its_x, ots_x, its_y, ots_y;

  int n_chk = 0, n_bad = 0, cycles = 0;
  logic hiz_mid;
  logic [15:0] pre_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_cfg_port i_addr_cfg_port (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .dev_addr(DEV),
    .csn(csn), .sclk(sclk), .sdi(sdi), .coef_rst_done(coef_rst_done),
    .out_hiz(out_hiz), .ctrl_x(ctrl_x), .its_x(its_x), .ots_x(ots_x),
    .ctrl_y(ctrl_y), .its_y(its_y), .ots_y(ots_y));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wclk(4);
    sclk = 1'b1; wclk(4);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [4:0][7:0] bytes, input int nbytes, input int extra_bits);
    hiz_mid = 1'b0;
    csn = 1'b0; wclk(4);
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 0; k < 8; k++) send_bit(bytes[i][k]);
      if (i == 0) begin
        wclk(4);
        hiz_mid = out_hiz;
      end
    end
    for (int k = 0; k < extra_bits; k++) send_bit(1'b1);
    wclk(4);
    pre_ctrl = {ctrl_x, ctrl_y};
    csn = 1'b1; wclk(8);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] exp_x;
    wclk(3); rst_n = 1'b1; wclk(2);
    // R1 reset state
    chk("R1 ctrl_x", 16'(ctrl_x), 16'h20);
    chk("R1 ctrl_y", 16'(ctrl_y), 16'h20);
    chk("R1 slots", {its_x, ots_x, 4'h0}, 16'h0);
    chk("R1 slots y", {its_y, ots_y, 4'h0}, 16'h0);
    chk("R1 hiz", 16'(out_hiz), 16'h0);

    // R2 / R3 / R8: sweep all addresses, two-byte write to X
    exp_x = 8'h20;
    for (int a = 0; a < 64; a++) begin
      logic [7:0] v;
      v = 8'({a[5:0], 2'b10}) ^ 8'h5A;
      xfer({24'h0, v, 2'b01, a[5:0]}, 2, 0);
      if (a[5:0] == DEV) exp_x = v;
      chk(a[5:0] == DEV ? "R2 match ctrl_x" : "R3 mismatch ctrl_x", 16'(ctrl_x), 16'(exp_x));
      chk("R8/R3 hiz during write", 16'(hiz_mid), 16'(a[5:0] == DEV));
      chk("R8 hiz released", 16'(out_hiz), 16'h0);
    end
    chk("R3 ctrl_y untouched", 16'(ctrl_y), 16'h20);

    // R6 four-byte write to Y, R11 no change before chip select rises
    xfer({8'h0, 8'h2A, 8'h15, 8'hC3, 2'b00, DEV}, 4, 0);
    chk("R11 ctrl held before commit", pre_ctrl, {exp_x, 8'h20});
    chk("R6 ctrl_y", 16'(ctrl_y), 16'hC3);
    chk("R6 its_y", 16'(its_y), 16'h15);
    chk("R6 ots_y", 16'(ots_y), 16'h2A);
    chk("R6 ctrl_x other side", 16'(ctrl_x), 16'(exp_x));

    // R5 two-byte write keeps slots
    xfer({24'h0, 8'h11, 2'b00, DEV}, 2, 0);
    chk("R5 ctrl_y", 16'(ctrl_y), 16'h11);
    chk("R5 its_y kept", 16'(its_y), 16'h15);
    chk("R5 ots_y kept", 16'(ots_y), 16'h2A);

    // R6 three-byte write to X
    xfer({16'h0, 8'h07, 8'h9D, 2'b01, DEV}, 3, 0);
    chk("R6 3B ctrl_x", 16'(ctrl_x), 16'h9D);
    chk("R6 3B its_x", 16'(its_x), 16'h07);
    chk("R6 3B ots_x kept", 16'(ots_x), 16'h00);

    // R4 reserved bit 7 set
    xfer({24'h0, 8'h99, 2'b11, DEV}, 2, 0);
    chk("R4 ctrl_x", 16'(ctrl_x), 16'h9D);
    chk("R4 hiz", 16'(hiz_mid), 16'h0);

    // R9 self-clearing algorithm reset
    coef_rst_done = 2'b10; wclk(1); coef_rst_done = 2'b00; wclk(1);
    chk("R9 ctrl_x bit4 cleared", 16'(ctrl_x), 16'h8D);
    chk("R9 ctrl_y kept", 16'(ctrl_y), 16'h11);
    coef_rst_done = 2'b01; wclk(1); coef_rst_done = 2'b00; wclk(1);
    chk("R9 ctrl_y bit4 cleared", 16'(ctrl_y), 16'h01);

    // R7 trailing partial byte discarded
    xfer({16'h0, 8'h3F, 8'h42, 2'b01, DEV}, 2, 5);
    chk("R7 partial ctrl_x", 16'(ctrl_x), 16'h42);
    chk("R7 partial its_x kept", 16'(its_x), 16'h07);
    // R7 fifth byte ignored
    xfer({8'hFF, 8'h21, 8'h0C, 8'h66, 2'b01, DEV}, 5, 0);
    chk("R7 5B ctrl_x", 16'(ctrl_x), 16'h66);
    chk("R7 5B its_x", 16'(its_x), 16'h0C);
    chk("R7 5B ots_x", 16'(ots_x), 16'h21);

    // R10 hardware mode
    hw_mode = 1'b1; wclk(2);
    xfer({8'h0, 8'h01, 8'h02, 8'hAA, 2'b01, DEV}, 4, 0);
    chk("R10 hiz", 16'(hiz_mid), 16'h0);
    chk("R10 ctrl_x", 16'(ctrl_x), 16'h66);
    chk("R10 slots", {4'h0, its_x, ots_x}, {4'h0, 6'h0C, 6'h21});
    hw_mode = 1'b0; wclk(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule